// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that runs from its own slow clock. It is separate from the bus clock, so it keeps counting if the system clock stops. Software reaches it through a 16-bit key port and two configuration ports, all in the bus clock domain. One key value starts the watchdog, one reloads the counter, and one unlocks the configuration ports for writing. Once the watchdog has started, only a reset can stop it. A strap input can also start it as it leaves reset.

A 12-bit down-counter steps once per prescaled tick. If the counter is at zero when a tick arrives, the block raises a reset request. That request stays high for a fixed number of watchdog clock cycles. The block also sets a sticky cause flag, which survives the system reset and is cleared only by power-on reset.

New prescaler and reload values cross into the watchdog clock through toggle handshakes. A busy output for each value stays high until its handshake has completed. A debug halt, qualified by a freeze enable, holds the count.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `count` is 0xFFF, `active`, `rst_req`, `busy_div` and `busy_rld` are 0, and with `hw_start` low `count` stays at 0xFFF until the watchdog is started.
- R2: Writing key 0xCCCC sets `active`. No later key value clears `active`; only `rst_n` does.
- R3: With `hw_start` high, `active` rises on the first watchdog clock edge after reset, and the count starts falling with no key written.
- R4: Writing key 0xAAAA while active copies the reload value into `count`. Before start it has no effect, and `count` stays 0xFFF.
- R5: Key 0x5555 unlocks the configuration ports. Key 0xAAAA and key 0xCCCC leave the unlock unchanged. Any other key value relocks the ports. A configuration write made while locked is ignored, and its busy output stays 0.
- R6: An accepted write to the prescaler or reload port raises its busy output on the next bus clock. Busy falls once the watchdog domain has taken the value. A write made while the busy output is high is dropped.
- R7: The prescaler code c in 3 bits gives one count step every 4·2^c watchdog clocks; codes 6 and 7 both give 256. The reset default is code 0.
- R8: A tick that finds `count` at 0 raises `rst_req` for exactly HOLD_CYC (default 16) watchdog clocks. In the same cycle the reload value is loaded into `count`.
- R9: `wd_flag` is set when `rst_req` is raised, is kept through `rst_n`, and is cleared only by `por_n`.
- R10: While `dbg_halt` and `freeze_en` are both high, `count` holds its value, though a refresh still loads it. If either input is low, counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| clk_wd | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset for the cause flag, active low |
| hw_start | input | 1 | Strap: start the watchdog out of reset |
| dbg_halt | input | 1 | Core halted in debug (watchdog domain) |
| freeze_en | input | 1 | Allow debug halt to freeze the count |
| key_we | input | 1 | Key write strobe |
| key_data | input | 16 | Key value |
| div_we | input | 1 | Prescaler write strobe |
| div_data | input | 3 | Prescaler code |
| rld_we | input | 1 | Reload write strobe |
| rld_data | input | 12 | Reload value |
| busy_div | output | 1 | Prescaler update in flight |
| busy_rld | output | 1 | Reload update in flight |
| active | output | 1 | Watchdog running (watchdog domain) |
| count | output | 12 | Current counter value (watchdog domain) |
| rst_req | output | 1 | Watchdog reset request |
| wd_flag | output | 1 | Sticky watchdog-reset cause |

## Verification
The assertions assume the following about the inputs:
- `hw_start` is stable for the whole time between resets.
- `dbg_halt` and `freeze_en` change only on the watchdog clock.
- Two refresh keys are written at least three watchdog clocks apart, because a toggle that returns to its old value before it is synchronized goes unseen.

The stimulus drives the debug inputs at the falling edge of the watchdog clock. After every key write it waits four watchdog clocks, and it changes the strap only while `rst_n` is low.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int CNT_W    = 12,
  parameter int KEY_W    = 16,
  parameter int DIV_W    = 3,
  parameter int PRE_W    = 8,
  parameter int HOLD_CYC = 16,
  parameter logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA,
  parameter logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555,
  parameter logic [KEY_W-1:0] KEY_START   = 16'hCCCC,
  localparam int HOLD_W = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk_bus,
  input  logic             clk_wd,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             hw_start,
  input  logic             dbg_halt,
  input  logic             freeze_en,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_data,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_data,
  input  logic             rld_we,
  input  logic [CNT_W-1:0] rld_data,
  output logic             busy_div,
  output logic             busy_rld,
  output logic             active,
  output logic [CNT_W-1:0] count,
  output logic             rst_req,
  output logic             wd_flag
);

  localparam logic [DIV_W-1:0] MAX_SHIFT = DIV_W'(PRE_W - 2);

  // bus domain
  logic             unlocked, start_bus, ref_tgl, div_req, rld_req;
  logic [DIV_W-1:0] div_sh;
  logic [CNT_W-1:0] rld_sh;
  logic [1:0]       div_ack_s, rld_ack_s;
  logic             div_ack_w, rld_ack_w;

  assign busy_div = div_req ^ div_ack_s[1];
  assign busy_rld = rld_req ^ rld_ack_s[1];

  always_ff @(posedge clk_bus or negedge rst_n) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      start_bus <= 1'b0;
      ref_tgl   <= 1'b0;
      div_req   <= 1'b0;
      rld_req   <= 1'b0;
      div_sh    <= '0;
      rld_sh    <= '1;
      div_ack_s <= '0;
      rld_ack_s <= '0;
    end else begin
      if (key_we) begin
        case (key_data)
          KEY_REFRESH: ref_tgl   <= ~ref_tgl;
          KEY_START:   start_bus <= 1'b1;
          KEY_UNLOCK:  unlocked  <= 1'b1;
          default:     unlocked  <= 1'b0;
        endcase
      end
      if (div_we && unlocked && !busy_div) begin
        div_sh  <= div_data;
        div_req <= ~div_req;
      end
      if (rld_we && unlocked && !busy_rld) begin
        rld_sh  <= rld_data;
        rld_req <= ~rld_req;
      end
      div_ack_s <= {div_ack_s[0], div_ack_w};
      rld_ack_s <= {rld_ack_s[0], rld_ack_w};
    end
  end

  // watchdog domain
  logic [2:0]        ref_s, div_s, rld_s;
  logic [1:0]        start_s;
  logic [DIV_W-1:0]  div_wd;
  logic [CNT_W-1:0]  rld_wd;
  logic [PRE_W-1:0]  pre_cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic [DIV_W-1:0]  shift;
  logic [PRE_W:0]    lim;
  logic              ref_hit, div_hit, rld_hit, frozen, tick, fire;

  assign ref_hit   = ref_s[2] ^ ref_s[1];
  assign div_hit   = div_s[2] ^ div_s[1];
  assign rld_hit   = rld_s[2] ^ rld_s[1];
  assign div_ack_w = div_s[2];
  assign rld_ack_w = rld_s[2];
  assign frozen    = dbg_halt & freeze_en;
  assign shift     = (div_wd > MAX_SHIFT) ? MAX_SHIFT : div_wd;
  assign lim       = (PRE_W+1)'(4) << shift;
  assign tick      = active && !frozen && ({1'b0, pre_cnt} == lim - 1'b1);
  assign fire      = tick && !ref_hit && (count == '0);
  assign rst_req   = (hold_cnt != '0);

  always_ff @(posedge clk_wd or negedge rst_n) begin
    if (!rst_n) begin
      ref_s   <= '0;
      div_s   <= '0;
      rld_s   <= '0;
      start_s <= '0;
      div_wd  <= '0;
      rld_wd  <= '1;
      active  <= 1'b0;
    end else begin
      ref_s   <= {ref_s[1:0], ref_tgl};
      div_s   <= {div_s[1:0], div_req};
      rld_s   <= {rld_s[1:0], rld_req};
      start_s <= {start_s[0], start_bus};
      if (div_hit) div_wd <= div_sh;
      if (rld_hit) rld_wd <= rld_sh;
      active <= active | hw_start | start_s[1];
    end
  end

  always_ff @(posedge clk_wd or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '1;
      pre_cnt  <= '0;
      hold_cnt <= '0;
    end else begin
      if (ref_hit && active) begin
        count   <= rld_wd;
        pre_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= '0;
        count   <= (count == '0) ? rld_wd : count - 1'b1;
      end else if (active && !frozen) begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (fire)               hold_cnt <= HOLD_W'(HOLD_CYC);
      else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_wd or negedge por_n) begin
    if (!por_n)    wd_flag <= 1'b0;
    else if (fire) wd_flag <= 1'b1;
  end

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int CNT_W    = 12,
  parameter int HOLD_CYC = 16
) (
  input logic             clk_bus,
  input logic             clk_wd,
  input logic             rst_n,
  input logic             por_n,
  input logic             hw_start,
  input logic             dbg_halt,
  input logic             freeze_en,
  input logic             active,
  input logic [CNT_W-1:0] count,
  input logic             rst_req,
  input logic             wd_flag,
  input logic             ref_hit,
  input logic             unlocked,
  input logic             busy_div,
  input logic             busy_rld
);

  logic [15:0] hi_cnt;
  always_ff @(posedge clk_wd or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (rst_req) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  assert_idle_count_R1: assert property (@(posedge clk_wd) disable iff (!rst_n)
    !active |-> count == '1);
  assert_active_sticky_R2: assert property (@(posedge clk_wd) disable iff (!rst_n)
    active |=> active);
  assert_strap_start_R3: assert property (@(posedge clk_wd) disable iff (!rst_n)
    hw_start |=> active);
  assert_locked_div_R5: assert property (@(posedge clk_bus) disable iff (!rst_n)
    (!unlocked && !busy_div) |=> !busy_div);
  assert_locked_rld_R5: assert property (@(posedge clk_bus) disable iff (!rst_n)
    (!unlocked && !busy_rld) |=> !busy_rld);
  assert_req_width_R8: assert property (@(posedge clk_wd) disable iff (!rst_n)
    (rst_req && hi_cnt < 16'(HOLD_CYC - 1)) |=> rst_req);
  assert_req_active_R8: assert property (@(posedge clk_wd) disable iff (!rst_n)
    rst_req |-> active);
  assert_flag_sticky_R9: assert property (@(posedge clk_wd) disable iff (!por_n)
    wd_flag |=> wd_flag);
  assert_req_flags_R9: assert property (@(posedge clk_wd) disable iff (!rst_n || !por_n)
    rst_req |-> wd_flag);
  assert_freeze_hold_R10: assert property (@(posedge clk_wd) disable iff (!rst_n)
    (dbg_halt && freeze_en && !ref_hit) |=> $stable(count));

endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_bus(clk_bus), .clk_wd(clk_wd), .rst_n(rst_n), .por_n(por_n),
  .hw_start(hw_start), .dbg_halt(dbg_halt), .freeze_en(freeze_en),
  .active(active), .count(count), .rst_req(rst_req), .wd_flag(wd_flag),
  .ref_hit(ref_hit), .unlocked(unlocked), .busy_div(busy_div), .busy_rld(busy_rld)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_PERIOD  = CLK_PERIOD * 3;
  localparam int HOLD       = 16;

  logic clk_bus = 0, clk_wd = 0;
  logic rst_n = 0, por_n = 0, hw_start = 0, dbg_halt = 0, freeze_en = 0;
  logic key_we = 0, div_we = 0, rld_we = 0;
  logic [15:0] key_data = 0;
  logic [2:0]  div_data = 0;
  logic [11:0] rld_data = 0;
  logic busy_div, busy_rld, active, rst_req, wd_flag;
  logic [11:0] count;

  always #(CLK_PERIOD/2) clk_bus = ~clk_bus;
  always #(WD_PERIOD/2)  clk_wd  = ~clk_wd;

  keyed_watchdog u_dut (
    .clk_bus(clk_bus), .clk_wd(clk_wd), .rst_n(rst_n), .por_n(por_n),
    .hw_start(hw_start), .dbg_halt(dbg_halt), .freeze_en(freeze_en),
    .key_we(key_we), .key_data(key_data), .div_we(div_we), .div_data(div_data),
    .rld_we(rld_we), .rld_data(rld_data), .busy_div(busy_div), .busy_rld(busy_rld),
    .active(active), .count(count), .rst_req(rst_req), .wd_flag(wd_flag)
  );

  typedef struct { string req; int exp; } item_t;
  item_t exp_q[$];
  int    obs_val;
  event  obs_ev;
  int    total = 0, bad = 0;
  bit    done = 0;

  initial forever begin
    @(obs_ev);
    if (exp_q.size() == 0) begin
      total++; bad++;
      $display("FAIL scoreboard: result with no expected item, actual=%0d", obs_val);
    end else begin
      item_t it;
      it = exp_q.pop_front();
      total++;
      if (obs_val != it.exp) begin
        bad++;
        $display("FAIL %s: actual=%0h expected=%0h", it.req, obs_val, it.exp);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    item_t it;
    it.req = req; it.exp = exp;
    exp_q.push_back(it);
    obs_val = act;
    -> obs_ev;
    #1;
  endtask

  task automatic wd_wait(int n);
    for (int i = 0; i < n; i++) @(negedge clk_wd);
  endtask

  task automatic key_wr(logic [15:0] k);
    @(negedge clk_bus); key_we = 1; key_data = k;
    @(negedge clk_bus); key_we = 0;
    wd_wait(4);
  endtask

  task automatic rld_wr(logic [11:0] v);
    @(negedge clk_bus); rld_we = 1; rld_data = v;
    @(negedge clk_bus); rld_we = 0;
  endtask

  task automatic div_wr(logic [2:0] v);
    @(negedge clk_bus); div_we = 1; div_data = v;
    @(negedge clk_bus); div_we = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && (busy_div || busy_rld); i++) @(negedge clk_bus);
  endtask

  task automatic interval(output int n);
    logic [11:0] c0;
    n = 0;
    @(negedge clk_wd); c0 = count;
    for (int i = 0; i < 600 && count == c0; i++) @(negedge clk_wd);
    c0 = count;
    for (int i = 0; i < 600 && count == c0; i++) begin @(negedge clk_wd); n++; end
  endtask

  task automatic do_reset(bit por);
    @(negedge clk_wd); rst_n = 0; if (por) por_n = 0;
    wd_wait(2);
    rst_n = 1; por_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    do_reset(1);
    wd_wait(2);
    check("R1 count", count, 12'hFFF);
    check("R1 active", active, 0);
    check("R1 rst_req", rst_req, 0);
    check("R1 busy", {busy_div, busy_rld}, 0);

    dbg_halt = 1; freeze_en = 1;
    key_wr(16'hAAAA);
    wd_wait(10);
    check("R4 refresh before start", count, 12'hFFF);

    rld_wr(12'h123); @(negedge clk_bus);
    check("R5 locked write", busy_rld, 0);
    key_wr(16'h5555); key_wr(16'h1234);
    rld_wr(12'h123); @(negedge clk_bus);
    check("R5 relocked by other key", busy_rld, 0);

    key_wr(16'h5555);
    rld_wr(12'h123);
    check("R6 busy raised", busy_rld, 1);
    rld_wr(12'h055);
    wait_idle();
    check("R6 busy cleared", busy_rld, 0);

    key_wr(16'hCCCC);
    wd_wait(4);
    check("R2 started", active, 1);
    wd_wait(20);
    check("R10 frozen count", count, 12'hFFF);
    key_wr(16'hAAAA);
    wd_wait(4);
    check("R4 refresh loads reload (R6 second write dropped)", count, 12'h123);

    freeze_en = 0;
    interval(n);
    check("R10 halt alone does not freeze, R7 code0 interval", n, 4);
    freeze_en = 1; dbg_halt = 0;
    interval(n);
    check("R10 freeze_en alone does not freeze", n, 4);

    div_wr(3'd1); wait_idle();
    interval(n);
    check("R7 code1 interval", n, 8);
    div_wr(3'd7); wait_idle();
    interval(n);
    check("R7 code7 interval", n, 256);
    div_wr(3'd0); wait_idle();

    key_wr(16'h0000);
    key_wr(16'h5555);
    check("R2 cannot stop", active, 1);
    rld_wr(12'd20); wait_idle();
    key_wr(16'hAAAA);
    for (int i = 0; i < 400 && !rst_req; i++) @(negedge clk_wd);
    check("R8 reload on fire", count, 20);
    check("R9 flag set", wd_flag, 1);
    n = 0;
    for (int i = 0; i < 100 && rst_req; i++) begin @(negedge clk_wd); n++; end
    check("R8 request width", n, HOLD);

    do_reset(0);
    wd_wait(3);
    check("R9 flag survives rst_n", wd_flag, 1);
    check("R1 inactive after reset", active, 0);
    do_reset(1);
    wd_wait(2);
    check("R9 por clears flag", wd_flag, 0);

    @(negedge clk_wd); rst_n = 0; hw_start = 1; dbg_halt = 0;
    wd_wait(2); rst_n = 1;
    wd_wait(2);
    check("R3 strap start", active, 1);
    wd_wait(40);
    check("R3 counting", int'(count < 12'hFFF), 1);

    finish_run();
  end
endmodule